// File: doc/BRIEF.md
# Banked Input-Change Interrupt Controller

This block watches a wide input port, split into equal banks, and drives one active-low interrupt line. Every pin has a direction bit (1 = input) and a mask bit (1 = masked). For each bank the block keeps a reference copy of the pin levels taken at the last read of that bank. The interrupt is raised when a pin is an input, is not masked, and its synchronised level differs from its reference bit.

Software services the interrupt by reading banks. A read strobe for a bank copies the synchronised pin levels of that bank into its reference copy and returns them on the read-data port one cycle later. A read clears only the differences inside that bank. The interrupt therefore stays active until every bank holding a differing pin has been read, or until the pins return to their reference levels without any read.

A three-state controller drives the line. ST_SEED is entered on reset. It holds the line released while every reference copy loads from the pins, and it always leaves for ST_QUIET (transition "seeded"). ST_QUIET keeps the line released and moves to ST_ALERT when any bank is pending (transition "raise"). ST_ALERT drives the line low and returns to ST_QUIET once no bank is pending (transition "release").

Top module: `bank_change_irq`

## Requirements
- R1: While reset is held and after it is released with stable pins, `irq_n` is high. Reset loads every reference copy from the synchronised pins.
- R2: A level change on an unmasked input pin drives `irq_n` low by the third rising clock edge after the change. The pin passes through a two-stage synchroniser and the state register.
- R3: A pin whose `pin_mask` bit is 1 never makes `irq_n` go low, whatever its level.
- R4: A pin whose `pin_is_input` bit is 0 (output) never makes `irq_n` go low, whatever its level.
- R5: When every differing pin returns to its reference level without a read, `irq_n` returns high. While any differing pin remains, `irq_n` stays low.
- R6: A one-hot strobe on `bank_rd[b]` reloads only the reference copy of bank b, where bank b is pins [8b+7:8b]. Reading a bank with no differing pin leaves the interrupt asserted.
- R7: When pins differ in several banks, `irq_n` stays low until each of those banks has been read. It returns high the cycle after the last of those reads.
- R8: On the rising edge where `bank_rd[b]` is the lowest set strobe bit, `rd_data` captures synchronised pins [8b+7:8b]. `rd_data` holds that value while no strobe is set.
- R9: Changing a pin from output to input while its level differs from its reference bit drives `irq_n` low one clock edge later.
- R10: Clearing the mask bit of an input pin whose level differs from its reference bit drives `irq_n` low one clock edge later.
- R11: With several strobe bits set on the same edge, every strobed bank reloads its reference copy, and `rd_data` returns the lowest-indexed strobed bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 40 | Asynchronous pin levels, bank b in bits [8b+7:8b] |
| pin_is_input | input | 40 | Direction per pin, 1 = input |
| pin_mask | input | 40 | Interrupt mask per pin, 1 = masked |
| bank_rd | input | 5 | Read strobe per bank |
| rd_data | output | 8 | Synchronised levels of the lowest strobed bank |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The main function is tried with single-pin toggles, two-pin toggles that revert one at a time, and simultaneous changes spread over three banks. Together these separate a level-compared interrupt from an edge-latched one, and a per-bank clear from a global clear. Reads of an unrelated bank, and paired strobes, show whether a read touches only its own reference copy. Masked pins and output pins are toggled and then enabled. The results show whether the mask and direction gate only the comparison and leave the reference copy alone, so that enabling the pin later raises the line.

// File: rtl/bank_irq_pkg.sv
package bank_irq_pkg;

    // Interrupt controller phases
    typedef enum logic [1:0] {
        ST_SEED  = 2'd0,  // reference copies loading after reset
        ST_QUIET = 2'd1,  // no pending bank, line released
        ST_ALERT = 2'd2   // at least one bank pending, line driven low
    } irq_state_e;

endpackage

// File: rtl/pin_sync2.sv
// Two-stage synchroniser for a vector of asynchronous pins.
module pin_sync2 #(
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        meta_q <= d_async;
        sync_q <= meta_q;
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/bank_tracker.sv
// One bank: reference copy of the pin levels and the pending flag.
module bank_tracker #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              rd_hit,
    input  logic [BANK_W-1:0] pins,
    input  logic [BANK_W-1:0] is_input,
    input  logic [BANK_W-1:0] mask,
    output logic              pending
);

    logic [BANK_W-1:0] ref_q;
    logic [BANK_W-1:0] live_diff;

    // Reference copy: loaded on reset, on the seed phase and on a read
    always_ff @(posedge clk) begin
        if (!rst_n || seed || rd_hit) begin
            ref_q <= pins;
        end
    end

    always_comb begin
        live_diff = (pins ^ ref_q) & is_input & ~mask;
        pending   = |live_diff;
    end

endmodule

// File: rtl/irq_fsm.sv
// Interrupt controller: seed, quiet and alert phases.
module irq_fsm
    import bank_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    output logic seed,
    output logic irq_n
);

    irq_state_e state_q;
    irq_state_e state_d;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED:  state_d = ST_QUIET;                          // seeded
            ST_QUIET: if (any_pend)  state_d = ST_ALERT;           // raise
            ST_ALERT: if (!any_pend) state_d = ST_QUIET;           // release
            default:  state_d = ST_SEED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        seed  = 1'b0;
        irq_n = 1'b1;
        unique case (state_q)
            ST_SEED:  seed  = 1'b1;
            ST_QUIET: irq_n = 1'b1;
            ST_ALERT: irq_n = 1'b0;
            default:  seed  = 1'b1;
        endcase
    end

endmodule

// File: rtl/bank_change_irq.sv
// Top: banked input-change interrupt controller.
module bank_change_irq #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_raw,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_is_input,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_mask,
    input  logic [NUM_BANKS-1:0]        bank_rd,
    output logic [BANK_W-1:0]           rd_data,
    output logic                        irq_n
);

    localparam int PIN_W = NUM_BANKS * BANK_W;

    logic [PIN_W-1:0]     pin_sync;
    logic [NUM_BANKS-1:0] bank_pend;
    logic                 seed_phase;
    logic [BANK_W-1:0]    rd_sel;

    pin_sync2 #(.WIDTH(PIN_W)) u_sync (
        .clk     (clk),
        .d_async (pin_raw),
        .q_sync  (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_tracker #(.BANK_W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .seed     (seed_phase),
            .rd_hit   (bank_rd[b]),
            .pins     (pin_sync[b*BANK_W +: BANK_W]),
            .is_input (pin_is_input[b*BANK_W +: BANK_W]),
            .mask     (pin_mask[b*BANK_W +: BANK_W]),
            .pending  (bank_pend[b])
        );
    end

    irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (|bank_pend),
        .seed     (seed_phase),
        .irq_n    (irq_n)
    );

    // Lowest-indexed strobed bank wins the read port
    always_comb begin
        rd_sel = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bank_rd[b]) begin
                rd_sel = pin_sync[b*BANK_W +: BANK_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (|bank_rd) begin
            rd_data <= rd_sel;
        end
    end

endmodule

// File: rtl/bank_change_irq_chk.sv
// Property checker attached to the top module.
module bank_change_irq_chk #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        irq_n,
    input logic                        seed,
    input logic [NUM_BANKS-1:0]        pend,
    input logic [NUM_BANKS*BANK_W-1:0] pin_sync,
    input logic [NUM_BANKS*BANK_W-1:0] pin_is_input,
    input logic [NUM_BANKS*BANK_W-1:0] pin_mask,
    input logic [NUM_BANKS-1:0]        bank_rd,
    input logic [BANK_W-1:0]           rd_data
);

    // R1: line released the edge after reset is seen
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> irq_n);

    // R2: a pending bank outside the seed phase raises the line
    p_pend_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pend) && !seed) |=> !irq_n);

    // R5: with no bank pending the line is released next edge
    p_idle_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |=> irq_n);

    // R3: fully masked port never pends
    p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&pin_mask) |-> (pend == '0));

    // R4: all-output port never pends
    p_output_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_is_input == '0) |-> (pend == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        localparam logic [NUM_BANKS-1:0] LOW_M = NUM_BANKS'((1 << b) - 1);

        // R6: a read clears its bank unless its inputs moved since
        p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            bank_rd[b] |=> (!pend[b]
                || (pin_sync[b*BANK_W +: BANK_W] != $past(pin_sync[b*BANK_W +: BANK_W]))
                || (pin_is_input[b*BANK_W +: BANK_W] != $past(pin_is_input[b*BANK_W +: BANK_W]))
                || (pin_mask[b*BANK_W +: BANK_W] != $past(pin_mask[b*BANK_W +: BANK_W]))));

        // R8: read data returns the lowest strobed bank
        p_rd_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_rd[b] && ((bank_rd & LOW_M) == '0))
                |=> (rd_data == $past(pin_sync[b*BANK_W +: BANK_W])));
    end

endmodule

bind bank_change_irq bank_change_irq_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_n        (irq_n),
    .seed         (seed_phase),
    .pend         (bank_pend),
    .pin_sync     (pin_sync),
    .pin_is_input (pin_is_input),
    .pin_mask     (pin_mask),
    .bank_rd      (bank_rd),
    .rd_data      (rd_data)
);

// File: tb/bank_change_irq_tb.sv
module bank_change_irq_tb_top;

    localparam int NB = 5;
    localparam int BW = 8;
    localparam int PW = NB * BW;
    localparam logic [PW-1:0] BASE = 40'h3C_96_A5_5A_C3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pin_raw = BASE;
    logic [PW-1:0] pin_is_input = '1;
    logic [PW-1:0] pin_mask = '0;
    logic [NB-1:0] bank_rd = '0;
    logic [BW-1:0] rd_data;
    logic          irq_n;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bank_change_irq #(.NUM_BANKS(NB), .BANK_W(BW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_raw      (pin_raw),
        .pin_is_input (pin_is_input),
        .pin_mask     (pin_mask),
        .bank_rd      (bank_rd),
        .rd_data      (rd_data),
        .irq_n        (irq_n)
    );

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [NB-1:0] sel);
        @(negedge clk) bank_rd = sel;
        @(negedge clk) bank_rd = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        settle(5);
        check("R1 irq during reset", PW'(irq_n), PW'(1));
        rst_n = 1'b1;
        settle(3);
        check("R1 irq after reset", PW'(irq_n), PW'(1));
        do_read(5'b00100);
        check("R8 rd_data bank2", PW'(rd_data), PW'(pin_raw[23:16]));
        settle(3);
        check("R8 rd_data held", PW'(rd_data), PW'(pin_raw[23:16]));
        do_read(5'b01010);
        check("R11 rd_data lowest strobe", PW'(rd_data), PW'(pin_raw[15:8]));
    endtask

    task automatic t_raise_revert();
        pin_raw[5] = ~pin_raw[5];
        settle(3);
        check("R2 change raises", PW'(irq_n), PW'(0));
        pin_raw[5] = ~pin_raw[5];
        settle(3);
        check("R5 revert releases", PW'(irq_n), PW'(1));
        pin_raw[12] = ~pin_raw[12];
        pin_raw[33] = ~pin_raw[33];
        settle(3);
        check("R2 two pins raise", PW'(irq_n), PW'(0));
        pin_raw[12] = ~pin_raw[12];
        settle(3);
        check("R5 partial revert stays", PW'(irq_n), PW'(0));
        pin_raw[33] = ~pin_raw[33];
        settle(3);
        check("R5 full revert releases", PW'(irq_n), PW'(1));
    endtask

    task automatic t_mask();
        pin_mask[9] = 1'b1;
        pin_raw[9]  = ~pin_raw[9];
        settle(4);
        check("R3 masked change ignored", PW'(irq_n), PW'(1));
        pin_mask[9] = 1'b0;
        settle(1);
        check("R10 unmask raises", PW'(irq_n), PW'(0));
        do_read(5'b00010);
        check("R8 rd_data bank1", PW'(rd_data), PW'(pin_raw[15:8]));
        settle(1);
        check("R6 read bank1 clears", PW'(irq_n), PW'(1));
    endtask

    task automatic t_direction();
        pin_is_input[20] = 1'b0;
        pin_raw[20] = ~pin_raw[20];
        settle(4);
        check("R4 output pin ignored", PW'(irq_n), PW'(1));
        pin_is_input[20] = 1'b1;
        settle(1);
        check("R9 output to input raises", PW'(irq_n), PW'(0));
        do_read(5'b00100);
        settle(1);
        check("R6 read bank2 clears", PW'(irq_n), PW'(1));
    endtask

    task automatic t_bank_clear();
        pin_raw[27] = ~pin_raw[27];
        settle(3);
        check("R2 bank3 change raises", PW'(irq_n), PW'(0));
        do_read(5'b10000);
        settle(1);
        check("R6 other bank read keeps", PW'(irq_n), PW'(0));
        do_read(5'b01000);
        settle(1);
        check("R6 own bank read clears", PW'(irq_n), PW'(1));
    endtask

    task automatic t_multi();
        pin_raw[2]  = ~pin_raw[2];
        pin_raw[19] = ~pin_raw[19];
        pin_raw[31] = ~pin_raw[31];
        settle(3);
        check("R7 multi raises", PW'(irq_n), PW'(0));
        do_read(5'b00001);
        settle(1);
        check("R7 after bank0 read", PW'(irq_n), PW'(0));
        do_read(5'b00100);
        settle(1);
        check("R7 after bank2 read", PW'(irq_n), PW'(0));
        do_read(5'b01000);
        settle(1);
        check("R7 after last read", PW'(irq_n), PW'(1));
        pin_raw[14] = ~pin_raw[14];
        pin_raw[38] = ~pin_raw[38];
        settle(3);
        check("R11 pair raises", PW'(irq_n), PW'(0));
        do_read(5'b10010);
        check("R11 rd_data bank1", PW'(rd_data), PW'(pin_raw[15:8]));
        settle(1);
        check("R11 paired read clears", PW'(irq_n), PW'(1));
    endtask

    initial begin
        t_reset();
        t_raise_revert();
        t_mask();
        t_direction();
        t_bank_clear();
        t_multi();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule